// File: doc/BRIEF.md
# Triggerable Variable-Frequency Cycle Oscillator

This block is a digital stand-in for an analog variable-frequency oscillator in a switching power controller. A phase accumulator adds an unsigned frequency control word on every clock. Each carry out of the accumulator ends the running cycle and requests a new one. The cycle rate therefore scales linearly with the control word. When a new cycle starts, the block emits a one-clock start pulse and arms a one-shot interval of programmable length. No further cycle may start until that interval has run out, so the interval sets the highest cycle rate.

Three inputs change the free-running behaviour. An asynchronous trigger passes through a two-flop synchronizer and an edge detector, and each rising edge cuts the running cycle short and restarts the phase. A synchronous disable lets the running cycle finish but holds off any new start. A start requested while disable is high, by a wrap or by a trigger, is remembered and released on the first clock at which disable is low again. Disable therefore wins over trigger. A global enable from the undervoltage logic clears the whole block while it is low.

Top module: `vfo_cycle_gen`

## Requirements
- R1: While rst_ni is low, cycle_o and busy_o are 0.
- R2: With dis_i low, no trigger, min_period_i at 0 and fcw_i = F, where F divides 65536, cycle_o pulses every 65536/F clocks. The first pulse appears in the (65536/F)-th cycle after the first clock edge that samples en_i high. An F of 0 gives no pulses.
- R3: A rising edge on trig_i gives exactly one start, however long trig_i stays high. If trig_i rises before clock edge e0, cycle_o is high in the cycle after edge e2. That start clears the phase, so the next wrap-driven start comes 65536/F clocks later.
- R4: cycle_o is never high in the cycle after a clock edge that samples dis_i high. A wrap or trigger that occurs while dis_i is high is held as pending.
- R5: A pending start fires on the first clock edge that samples dis_i low, with a wrap in the meantime not needed, so cycle_o is high in the cycle that follows.
- R6: With min_period_i = M, held constant while en_i is high, consecutive starts are at least M clocks apart. A value of 0 or 1 sets no limit. A start blocked by the interval stays pending and fires exactly M clocks after the previous start.
- R7: busy_o is high for M clocks, beginning in the cycle in which cycle_o pulses. If another start comes at the end of that window, busy_o stays high.
- R8: In the cycle after an edge that samples en_i low, cycle_o and busy_o are 0, the phase is zero and any pending start is dropped. A trigger that arrives while en_i is low is lost.
- R9: Each start produces a cycle_o pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable from the undervoltage logic |
| fcw_i | input | FCW_W | Unsigned frequency control word |
| trig_i | input | 1 | Asynchronous trigger; its rising edge restarts the cycle |
| dis_i | input | 1 | Synchronous oscillator disable |
| min_period_i | input | OS_W | One-shot length in clocks, which sets the minimum start spacing |
| cycle_o | output | 1 | One-clock cycle-start pulse |
| busy_o | output | 1 | High while the one-shot interval is active |

## Verification
The spacing and busy properties assume that min_period_i changes only while en_i is low. The checker latches it on each start, and the busy check reads it in the cycle of the pulse. The disable property assumes dis_i is already synchronous to clk_i. The stimulus changes fcw_i, min_period_i and dis_i only at falling clock edges, and alters min_period_i only during the two low-enable clocks that open each test. Trigger pulses are held for at least one full clock, so the synchronizer always captures them.

// File: rtl/vfo_pkg.sv
package vfo_pkg;

  // sources that may ask for a new cycle in one clock
  typedef struct packed {
    logic wrap;
    logic trig;
    logic held;
  } vfo_req_t;

  function automatic logic any_req(vfo_req_t r);
    return r.wrap | r.trig | r.held;
  endfunction

endpackage

// File: rtl/vfo_trig_sync.sv
module vfo_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= trig_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  // last stage acts as history for the rising-edge detect
  assign edge_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/vfo_phase_acc.sv
module vfo_phase_acc #(
  parameter int FCW_W = 16,
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [FCW_W-1:0] fcw_i,
  output logic             wrap_o
);
  localparam int PAD_W = ACC_W - FCW_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc;
  logic [ACC_W:0]   sum;

  if (PAD_W == 0) begin : g_same_w
    assign inc = fcw_i;
  end else begin : g_pad
    assign inc = {{PAD_W{1'b0}}, fcw_i};
  end

  assign sum    = {1'b0, acc_q} + {1'b0, inc};
  assign wrap_o = en_i & sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             acc_q <= '0;
    else if (!en_i || clr_i) acc_q <= '0;
    else                     acc_q <= sum[ACC_W-1:0];
  end

endmodule

// File: rtl/vfo_oneshot.sv
module vfo_oneshot #(
  parameter int OS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            fire_i,
  input  logic [OS_W-1:0] len_i,
  output logic            ready_o,
  output logic            busy_o
);
  logic [OS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (fire_i)      cnt_q <= len_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // a start may land on the last clock of the interval
  assign ready_o = (cnt_q <= OS_W'(1));
  assign busy_o  = (cnt_q != '0);

endmodule

// File: rtl/vfo_start_ctrl.sv
module vfo_start_ctrl
  import vfo_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     dis_i,
  input  vfo_req_t req_i,
  input  logic     ready_i,
  output logic     fire_o,
  output logic     held_o,
  output logic     start_o
);
  logic held_q;
  logic start_q;
  logic want;

  assign want   = any_req(req_i);
  assign fire_o = en_i & want & ~dis_i & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= fire_o;
      if (!en_i || fire_o) held_q <= 1'b0;
      else if (want)       held_q <= 1'b1;
    end
  end

  assign held_o  = held_q;
  assign start_o = start_q;

endmodule

// File: rtl/vfo_cycle_gen.sv
module vfo_cycle_gen
  import vfo_pkg::*;
#(
  parameter int FCW_W       = 16,
  parameter int ACC_W       = 16,
  parameter int OS_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [FCW_W-1:0] fcw_i,
  input  logic             trig_i,
  input  logic             dis_i,
  input  logic [OS_W-1:0]  min_period_i,
  output logic             cycle_o,
  output logic             busy_o
);
  vfo_req_t req;
  logic     trig_edge;
  logic     wrap;
  logic     held;
  logic     fire;
  logic     ready;

  vfo_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .edge_o (trig_edge)
  );

  vfo_phase_acc #(.FCW_W(FCW_W), .ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .clr_i  (any_req(req)),
    .fcw_i  (fcw_i),
    .wrap_o (wrap)
  );

  assign req.wrap = wrap;
  assign req.trig = en_i & trig_edge;
  assign req.held = held;

  vfo_oneshot #(.OS_W(OS_W)) u_os (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .fire_i  (fire),
    .len_i   (min_period_i),
    .ready_o (ready),
    .busy_o  (busy_o)
  );

  vfo_start_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .dis_i   (dis_i),
    .req_i   (req),
    .ready_i (ready),
    .fire_o  (fire),
    .held_o  (held),
    .start_o (cycle_o)
  );

endmodule

// File: rtl/vfo_cycle_gen_chk.sv
module vfo_cycle_gen_chk #(
  parameter int OS_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            dis_i,
  input logic [OS_W-1:0] min_period_i,
  input logic            cycle_o,
  input logic            busy_o
);
  localparam int GAP_W = OS_W + 1;

  logic             armed_q;
  logic [GAP_W-1:0] gap_q;
  logic [OS_W-1:0]  min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
      min_q   <= '0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else if (cycle_o) begin
      armed_q <= 1'b1;
      gap_q   <= GAP_W'(1);
      min_q   <= min_period_i;
    end else if (gap_q != '1) begin
      gap_q   <= gap_q + 1'b1;
    end
  end

  p_dis_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !cycle_o);

  p_min_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o && armed_q) |-> (gap_q >= GAP_W'(min_q)));

  p_busy_on_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o && (min_period_i != '0)) |-> busy_o);

  p_en_low_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!cycle_o && !busy_o));

endmodule

bind vfo_cycle_gen vfo_cycle_gen_chk #(.OS_W(OS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .dis_i        (dis_i),
  .min_period_i (min_period_i),
  .cycle_o      (cycle_o),
  .busy_o       (busy_o)
);

// File: tb/vfo_cycle_gen_tb_top.sv
module vfo_cycle_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int N_VEC = 9;
  localparam int VEC_CLK = 64;
  localparam logic [15:0] VEC_FCW [N_VEC] = '{16'h4000, 16'h2000, 16'h1000, 16'h0800,
                                              16'h8000, 16'h0000, 16'h8000, 16'hFFFF, 16'h4000};
  localparam logic [15:0] VEC_MIN [N_VEC] = '{16'd0, 16'd0, 16'd0, 16'd0,
                                              16'd0, 16'd0, 16'd4, 16'd0, 16'd8};
  localparam int VEC_EXP [N_VEC] = '{16, 8, 4, 2, 32, 0, 16, 32, 8};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] fcw_i = '0;
  logic        trig_i = 1'b0;
  logic        dis_i = 1'b0;
  logic [15:0] min_period_i = '0;
  logic        cycle_o;
  logic        busy_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  vfo_cycle_gen dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .fcw_i        (fcw_i),
    .trig_i       (trig_i),
    .dis_i        (dis_i),
    .min_period_i (min_period_i),
    .cycle_o      (cycle_o),
    .busy_o       (busy_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // two low-enable clocks, new settings, enable set so the next edge is e0
  task automatic restart_en(logic [15:0] f, logic [15:0] m);
    en_i = 1'b0;
    dis_i = 1'b0;
    trig_i = 1'b0;
    tick();
    tick();
    fcw_i = f;
    min_period_i = m;
    en_i = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int cnt, first, second, idx;
    logic [23:0] cyc, bsy;

    // R1 reset state
    tick();
    tick();
    chk("R1 cycle_o in reset", int'(cycle_o), 0);
    chk("R1 busy_o in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    tick();

    // R2 R6 table of rates and clamps
    for (int v = 0; v < N_VEC; v++) begin
      restart_en(VEC_FCW[v], VEC_MIN[v]);
      cnt = 0;
      for (int i = 0; i < VEC_CLK; i++) begin
        tick();
        if (cycle_o) cnt++;
      end
      chk($sformatf("R2/R6 vector %0d pulse count", v), cnt, VEC_EXP[v]);
    end

    // R3 R9 trigger restart, held high gives one start
    restart_en(16'h0100, 16'd0);
    for (int i = 0; i < 20; i++) tick();
    trig_i = 1'b1;
    cnt = 0; first = -1; second = -1;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (i == 5) trig_i = 1'b0;
      if (cycle_o) begin
        if (cnt == 0) first = i;
        else if (cnt == 1) second = i;
        cnt++;
      end
    end
    chk("R3 trigger start cycle", first, 2);
    chk("R3 wrap start after phase restart", second, 258);
    chk("R9 R3 one start per trigger edge", cnt, 2);

    // R4 R5 disable lets cycle end, holds start, releases at once
    restart_en(16'h4000, 16'd0);
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      tick();
      if (cycle_o) first = i;
    end
    chk("R2 first start before disable", first, 3);
    dis_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (cycle_o) cnt++;
    end
    chk("R4 no start while disabled", cnt, 0);
    dis_i = 1'b0;
    tick();
    chk("R5 pending wrap released", int'(cycle_o), 1);
    tick();
    chk("R9 start pulse one clock wide", int'(cycle_o), 0);
    tick();
    tick();
    chk("R5 period resumes after release (idle)", int'(cycle_o), 0);
    tick();
    chk("R5 period resumes after release", int'(cycle_o), 1);

    // R4 R5 trigger during disable is stored
    restart_en(16'h0000, 16'd0);
    dis_i = 1'b1;
    tick();
    trig_i = 1'b1;
    tick();
    trig_i = 1'b0;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (cycle_o) cnt++;
    end
    chk("R4 trigger blocked by disable", cnt, 0);
    dis_i = 1'b0;
    tick();
    chk("R5 stored trigger released", int'(cycle_o), 1);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (cycle_o) cnt++;
    end
    chk("R5 stored trigger fires once", cnt, 0);

    // R6 R7 second trigger inside one-shot waits for it
    restart_en(16'h0000, 16'd10);
    trig_i = 1'b1;
    for (int i = 0; i < 24; i++) begin
      tick();
      if (i == 0) trig_i = 1'b0;
      if (i == 3) trig_i = 1'b1;
      if (i == 4) trig_i = 1'b0;
      cyc[i] = cycle_o;
      bsy[i] = busy_o;
    end
    idx = 0;
    for (int i = 0; i < 24; i++) if (cyc[i] && i != 2 && i != 12) idx++;
    chk("R6 first start", int'(cyc[2]), 1);
    chk("R6 held start after interval", int'(cyc[12]), 1);
    chk("R6 no other starts", idx, 0);
    chk("R7 busy low before start", int'(bsy[1]), 0);
    chk("R7 busy with start", int'(bsy[2]), 1);
    chk("R7 busy last clock of interval", int'(bsy[11]), 1);
    chk("R7 busy end of second interval", int'(bsy[21]), 1);
    chk("R7 busy clears", int'(bsy[22]), 0);

    // R8 enable low clears and drops triggers
    restart_en(16'h8000, 16'd6);
    for (int i = 0; i < 8; i++) tick();
    chk("R8 busy high before enable drop", int'(busy_o), 1);
    en_i = 1'b0;
    tick();
    chk("R8 cycle_o after enable low", int'(cycle_o), 0);
    chk("R8 busy_o after enable low", int'(busy_o), 0);
    trig_i = 1'b1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (i == 1) trig_i = 1'b0;
      if (cycle_o || busy_o) cnt++;
    end
    fcw_i = 16'h0000;
    en_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (cycle_o) cnt++;
    end
    chk("R8 quiet and trigger lost", cnt, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule